// File: doc/BRIEF.md
# Serial EEPROM Target (16-bit words, four-wire)

This block behaves like a small serial EEPROM on a select/clock/data-in/data-out link. It holds 256 sixteen-bit words in a register file. The system clock oversamples the slow serial lines. The host raises select and clocks in a frame: one start bit, a two-bit opcode and an eight-bit address. Write frames carry sixteen data bits after the address. Reads return data on the output line. Erase and write commands are armed by the frame and launched when select falls. A self-timed programming interval follows, lasting `PROG_CYCLES` system clocks.

While programming runs, raising select shows a busy/ready flag on the data output. The output is driven only during a read transfer or while that flag is shown. The driver enable is a separate pin, so a pad or a bus keeper can build the tri-state line. A protection latch is clear after reset. Until an enable command has run, every erase and write command is dropped.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame begins at the first `din` = 1 sampled on a rising `sck` while `cs` is high, and any 0 bits before it are skipped. The next two bits are the opcode and the eight after that the address, both MSB first. Opcode 10 is read, 01 is write and 11 is erase. Opcode 00 selects by address bits [7:6]: 11 enables programming, 10 erases all, 01 writes all and 00 disables programming.
- R2: A read frame's last address edge drives `so_d` = 0 with `so_oe` = 1. Each of the next 16 rising `sck` edges presents one bit of the addressed word, MSB first. The following edge releases the output.
- R3: After reset every word reads 16'hFFFF.
- R4: After reset programming is disabled, and erase and write commands have no effect and start no busy phase. The enable command lifts this, and the disable command or reset restores it.
- R5: Reads return stored data whether programming is enabled or not.
- R6: A write frame takes 16 data bits, MSB first, after the address. The falling `cs` that follows the last data bit starts programming, and the word then holds the data.
- R7: Erase sets the addressed word to 16'hFFFF, and erase-all sets every word to 16'hFFFF. Both start programming on the `cs` fall that follows the last address bit.
- R8: Write-all stores its 16 data bits in every word.
- R9: Programming lasts `PROG_CYCLES` system clocks. While `cs` is high after a programming start, `so_oe` = 1 and `so_d` is 0 while busy and 1 once complete.
- R10: `so_oe` is 0 whenever `cs` is low and whenever neither a read transfer nor the status flag is active.
- R11: While programming is busy, every frame is ignored, including reads, writes and enable/disable commands.
- R12: A frame cut short by `cs` falling before its last bit changes no word and starts no programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Select; a high level frames a command |
| sck | input | 1 | Serial clock; bits move on its rising edge |
| din | input | 1 | Serial command, address and data input |
| so_d | output | 1 | Serial output value (read data or busy/ready) |
| so_oe | output | 1 | Output driver enable; 0 means high impedance |

## Verification
The hardest case to reach is a complete, well-formed command arriving while a programming interval is still running. The write command must be fully clocked in and select dropped, and the command must still leave the array untouched. To set this up, the bench makes the busy interval longer than a whole write frame. It launches one write, then immediately clocks in a second write to a different word. Once ready is seen, it reads both words back and expects only the first to have changed.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic din,
  output logic so_d,
  output logic so_oe
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CMAX  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int PW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_DAT, S_RD, S_DONE, S_END} st_t;
  typedef enum logic [2:0] {OP_NONE, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL} op_t;

  logic [2:0]        cs_sr, sck_sr;
  logic [1:0]        din_sr;
  logic              cs_q, din_q, sck_rise, cs_fall;
  st_t               st;
  op_t               pop;
  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] adr, a_nxt;
  logic [DATA_W-1:0] dsr;
  logic [DATA_W:0]   rsr;
  logic              wen, busy, stat_pend, rd_on, commit;
  logic [PW-1:0]     pcnt;
  logic [DATA_W-1:0] mem [WORDS];

  assign cs_q     = cs_sr[1];
  assign din_q    = din_sr[1];
  assign sck_rise = sck_sr[1] & ~sck_sr[2];
  assign cs_fall  = cs_sr[2] & ~cs_sr[1];
  assign a_nxt    = {adr[ADDR_W-2:0], din_q};
  assign rd_on    = (st == S_RD);
  assign commit   = busy && (pcnt == '0);
  assign so_oe    = cs_q & (stat_pend | rd_on);
  assign so_d     = so_oe & (stat_pend ? ~busy : rsr[DATA_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr     <= '0;
      sck_sr    <= '0;
      din_sr    <= '0;
      st        <= S_IDLE;
      pop       <= OP_NONE;
      cnt       <= '0;
      opc       <= '0;
      adr       <= '0;
      dsr       <= '0;
      rsr       <= '0;
      wen       <= 1'b0;
      busy      <= 1'b0;
      pcnt      <= '0;
      stat_pend <= 1'b0;
    end else begin
      cs_sr  <= {cs_sr[1:0], cs};
      sck_sr <= {sck_sr[1:0], sck};
      din_sr <= {din_sr[0], din};

      if (busy) begin
        if (pcnt == '0) busy <= 1'b0;
        else            pcnt <= pcnt - 1'b1;
      end else if (cs_fall && st == S_DONE && wen) begin
        busy      <= 1'b1;
        pcnt      <= PW'(PROG_CYCLES - 1);
        stat_pend <= 1'b1;
      end

      if (!cs_q) begin
        st <= S_IDLE;
      end else if (sck_rise && !busy) begin
        case (st)
          S_IDLE: if (din_q) begin
            st        <= S_OPC;
            cnt       <= '0;
            pop       <= OP_NONE;
            stat_pend <= 1'b0;
          end
          S_OPC: begin
            opc <= {opc[0], din_q};
            if (cnt == CW'(1)) begin
              st  <= S_ADR;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_ADR: begin
            adr <= a_nxt;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(ADDR_W - 1)) begin
              cnt <= '0;
              case (opc)
                2'b10: begin
                  rsr <= {1'b0, mem[a_nxt]};
                  st  <= S_RD;
                end
                2'b01: begin
                  pop <= OP_WRITE;
                  st  <= S_DAT;
                end
                2'b11: begin
                  pop <= OP_ERASE;
                  st  <= S_DONE;
                end
                default: case (a_nxt[ADDR_W-1 -: 2])
                  2'b11: begin
                    wen <= 1'b1;
                    st  <= S_END;
                  end
                  2'b10: begin
                    pop <= OP_ERAL;
                    st  <= S_DONE;
                  end
                  2'b01: begin
                    pop <= OP_WRAL;
                    st  <= S_DAT;
                  end
                  default: begin
                    wen <= 1'b0;
                    st  <= S_END;
                  end
                endcase
              endcase
            end
          end
          S_DAT: begin
            dsr <= {dsr[DATA_W-2:0], din_q};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DATA_W - 1)) st <= S_DONE;
          end
          S_RD: begin
            rsr <= {rsr[DATA_W-1:0], 1'b0};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DATA_W)) st <= S_END;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (commit) begin
      case (pop)
        OP_WRITE: mem[adr] <= dsr;
        OP_ERASE: mem[adr] <= '1;
        OP_ERAL:  for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        OP_WRAL:  for (int i = 0; i < WORDS; i++) mem[i] <= dsr;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk #(
  parameter int PROG_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_q,
  input logic busy,
  input logic wen,
  input logic rd_on,
  input logic so_d,
  input logic so_oe
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  p_dummy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_on) |-> (so_oe && !so_d));

  p_busy_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_q) |-> (so_oe && !so_d));

  p_prog_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == PROG_CYCLES));

  p_prog_needs_wen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);

  p_wen_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wen));

  p_no_read_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_on |-> !busy);

  p_oe_off_cs_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !so_oe);
endmodule

bind uwire_eeprom uwire_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_q  (cs_q),
  .busy  (busy),
  .wen   (wen),
  .rd_on (rd_on),
  .so_d  (so_d),
  .so_oe (so_oe)
);

// File: tb/test_uwire_eeprom.sv
module test_uwire_eeprom;
  localparam int PROG = 600;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, din = 1'b0;
  logic so_d, so_oe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uwire_eeprom #(.ADDR_W(8), .DATA_W(16), .PROG_CYCLES(PROG)) i_uwire_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din),
    .so_d(so_d), .so_oe(so_oe)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b);
    din = b;
    tick(HALF);
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1;
    tick(HALF);
  endtask

  task automatic cs_down();
    cs = 1'b0;
    din = 1'b0;
    tick(HALF);
  endtask

  task automatic head(input logic [1:0] op, input logic [7:0] a);
    bitx(1'b1);
    bitx(op[1]);
    bitx(op[0]);
    for (int i = 7; i >= 0; i--) bitx(a[i]);
  endtask

  task automatic prog(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d, input int nbits);
    cs_up();
    head(op, a);
    for (int i = 0; i < nbits; i++) bitx(d[15-i]);
    cs_down();
  endtask

  task automatic wait_prog(input string tag);
    cs_up();
    chk(so_oe === 1'b1 && so_d === 1'b0, {tag, " R9 busy flag"}, {so_oe, so_d}, 2'b10);
    tick(PROG + 40);
    chk(so_oe === 1'b1 && so_d === 1'b1, {tag, " R9 ready flag"}, {so_oe, so_d}, 2'b11);
    cs_down();
  endtask

  task automatic rd(input logic [7:0] a, input int lead, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    logic dummy_ok, rel_ok;
    v = '0;
    cs_up();
    for (int i = 0; i < lead; i++) bitx(1'b0);
    head(2'b10, a);
    dummy_ok = (so_oe === 1'b1) && (so_d === 1'b0);
    for (int i = 15; i >= 0; i--) begin
      bitx(1'b0);
      v[i] = so_d;
    end
    bitx(1'b0);
    rel_ok = (so_oe === 1'b0);
    cs_down();
    chk(v === exp, tag, v, exp);
    chk(dummy_ok, "R2 dummy zero before data", dummy_ok, 1);
    chk(rel_ok, "R2 R10 output released after last bit", rel_ok, 1);
  endtask

  task automatic t_reset();
    chk(so_oe === 1'b0, "R10 idle after reset", so_oe, 0);
    rd(8'd5, 0, 16'hFFFF, "R3 erased word after reset");
    rd(8'd255, 0, 16'hFFFF, "R3 top word after reset");
  endtask

  task automatic t_locked();
    prog(2'b01, 8'd3, 16'h1234, 16);
    cs_up();
    chk(so_oe === 1'b0, "R4 no busy phase while disabled", so_oe, 0);
    cs_down();
    rd(8'd3, 0, 16'hFFFF, "R4 R5 write dropped while disabled");
  endtask

  task automatic t_write();
    prog(2'b00, 8'hC0, 16'h0, 0);
    prog(2'b01, 8'd3, 16'hA5C3, 16);
    wait_prog("write");
    rd(8'd3, 0, 16'hA5C3, "R6 written word");
    prog(2'b01, 8'd200, 16'h5A3C, 16);
    wait_prog("write2");
    rd(8'd200, 0, 16'h5A3C, "R6 second written word");
    rd(8'd4, 0, 16'hFFFF, "R6 neighbour untouched");
  endtask

  task automatic t_erase();
    prog(2'b11, 8'd3, 16'h0, 0);
    wait_prog("erase");
    rd(8'd3, 0, 16'hFFFF, "R7 erased word");
    rd(8'd200, 0, 16'h5A3C, "R7 other word kept by erase");
  endtask

  task automatic t_all();
    prog(2'b00, 8'h40, 16'h0F0F, 16);
    wait_prog("wral");
    rd(8'd0, 0, 16'h0F0F, "R8 write-all word 0");
    rd(8'd255, 0, 16'h0F0F, "R8 write-all word 255");
    prog(2'b00, 8'h80, 16'h0, 0);
    wait_prog("eral");
    rd(8'd0, 0, 16'hFFFF, "R7 erase-all word 0");
    rd(8'd128, 0, 16'hFFFF, "R7 erase-all word 128");
  endtask

  task automatic t_busy();
    prog(2'b01, 8'd7, 16'h1357, 16);
    cs_up();
    chk(so_oe === 1'b1 && so_d === 1'b0, "R9 busy at start", {so_oe, so_d}, 2'b10);
    cs_down();
    prog(2'b01, 8'd8, 16'h0000, 16);
    cs_up();
    chk(so_d === 1'b0, "R11 still busy after ignored frame", so_d, 0);
    tick(PROG + 40);
    chk(so_d === 1'b1, "R9 ready after busy", so_d, 1);
    cs_down();
    rd(8'd7, 0, 16'h1357, "R11 first write landed");
    rd(8'd8, 0, 16'hFFFF, "R11 frame during busy ignored");
  endtask

  task automatic t_abort();
    prog(2'b01, 8'd9, 16'h0000, 8);
    cs_up();
    chk(so_oe === 1'b0, "R12 no busy phase after abort", so_oe, 0);
    cs_down();
    rd(8'd9, 0, 16'hFFFF, "R12 aborted write left word");
  endtask

  task automatic t_disable();
    prog(2'b00, 8'h00, 16'h0, 0);
    prog(2'b01, 8'd7, 16'h0000, 16);
    cs_up();
    chk(so_oe === 1'b0, "R4 no busy phase after disable", so_oe, 0);
    cs_down();
    rd(8'd7, 0, 16'h1357, "R4 R5 write dropped after disable");
  endtask

  task automatic t_lead();
    rd(8'd7, 3, 16'h1357, "R1 leading zeros skipped");
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_locked();
    t_write();
    t_erase();
    t_all();
    t_busy();
    t_abort();
    t_disable();
    t_lead();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule